// File: doc/BRIEF.md
# Bidirectional Logarithmic Barrel Shifter

This block moves a data word left or right by any distance from zero to one less than the word width in a single combinational pass. A binary shift amount drives a cascade of stages. Stage k either passes its input unchanged or moves it by 2^k positions, depending on bit k of the amount. The default width is 16 bits, which gives stages for 8, 4, 2 and 1 positions. A single direction input steers every stage the same way.

There are three ways to treat the bits that a shift vacates. The first fills them with zeros. The second fills them with copies of the input's top bit, which is the sign-preserving right shift used for signed division by powers of two. The third is a rotation, in which the bits that leave one end of the word enter at the other end. The surrounding datapath feeds the word and the controls and takes the result in the same cycle. There is no register inside the block.

Top module: `bsh_top`

## Requirements
- R1: When `amt` is 0, `dout` equals `din` for every setting of `dir_left`, `fill_sign` and `wrap_en`.
- R2: With `dir_left`=1 and `wrap_en`=0, `dout` equals `din` shifted toward the top bit by `amt` positions, and the low `amt` bits are 0.
- R3: With `dir_left`=0, `wrap_en`=0 and `fill_sign`=0, `dout` equals `din` shifted toward bit 0 by `amt` positions, and the top `amt` bits are 0.
- R4: With `dir_left`=0, `wrap_en`=0 and `fill_sign`=1, the top `amt` bits of `dout` all equal `din[W-1]` and the remaining bits are `din` shifted toward bit 0. For example, `amt`=W-1 gives every bit equal to `din[W-1]`.
- R5: With `dir_left`=0 and `wrap_en`=1, output bit i equals input bit (i+amt) mod W. For example, rotating 16'h0001 by 1 gives 16'h8000.
- R6: With `dir_left`=1 and `wrap_en`=1, output bit i equals input bit (i-amt) mod W. For example, rotating 16'h8000 by 1 gives 16'h0001.
- R7: `fill_sign` has no effect on `dout` when `dir_left`=1 or `wrap_en`=1.
- R8: `amt` is an unsigned binary number, and every value from 0 to W-1 is valid. At the maximum amount, a zero-fill left shift leaves only `din[0]`, placed in bit W-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | W (16) | Word to be shifted |
| amt | input | log2(W) (4) | Unsigned shift distance |
| dir_left | input | 1 | 1 moves toward the top bit, 0 moves toward bit 0 |
| fill_sign | input | 1 | For right shifts, 1 fills with `din[W-1]` and 0 fills with zeros |
| wrap_en | input | 1 | 1 rotates instead of filling |
| dout | output | W (16) | Shifted word |

## Verification
The hardest cases to reach are those where several stages are active at once and the fill comes from the original sign bit rather than from the word partway through the cascade. An arithmetic right shift whose amount has several bits set, applied to a negative word, must still fill every vacated bit with the sign. The same holds for a rotation in which bits wrap in more than one stage. To reach these cases, the stimulus sweeps every amount in every direction and fill combination across a set of words. The set includes a lone top bit, a lone bottom bit, alternating patterns and pseudo-random values. For left shifts and rotations, each case is then repeated with the fill bit flipped.

// File: rtl/bsh_pkg.sv
package bsh_pkg;

    // Default data width; must be a power of two, at least 2.
    parameter int unsigned DW_DEFAULT = 16;

    // How the bits vacated by one stage are supplied.
    typedef enum logic [1:0] {
        FILL_ZERO = 2'd0,
        FILL_SIGN = 2'd1,
        FILL_WRAP = 2'd2
    } fill_kind_e;

    // Control shared by every stage of the cascade.
    typedef struct packed {
        logic       go_left;
        fill_kind_e kind;
        logic       fill_bit;
    } stage_ctl_t;

    // Shift distance of the stage driven by amount bit k.
    function automatic int unsigned stage_dist(input int unsigned k);
        return 32'd1 << k;
    endfunction

    // Resolve the fill kind from the raw controls.
    // Wrapping wins over the fill bit, and sign fill applies to right shifts only.
    function automatic fill_kind_e pick_kind(input logic left, input logic sign, input logic wrap);
        if (wrap)
            return FILL_WRAP;
        else if (sign && !left)
            return FILL_SIGN;
        else
            return FILL_ZERO;
    endfunction

endpackage

// File: rtl/bsh_ctl.sv
module bsh_ctl
    import bsh_pkg::*;
#(
    parameter int unsigned W = DW_DEFAULT
) (
    input  logic         msb,
    input  logic         dir_left,
    input  logic         fill_sign,
    input  logic         wrap_en,
    output stage_ctl_t   ctl
);

    fill_kind_e kind;

    always_comb begin
        kind         = pick_kind(dir_left, fill_sign, wrap_en);
        ctl.go_left  = dir_left;
        ctl.kind     = kind;
        // The fill bit is taken once from the original word, so every stage
        // copies the true sign no matter how many stages are active.
        ctl.fill_bit = (kind == FILL_SIGN) ? msb : 1'b0;
    end

endmodule

// File: rtl/bsh_stage.sv
module bsh_stage
    import bsh_pkg::*;
#(
    parameter int unsigned W    = DW_DEFAULT,
    parameter int unsigned DIST = 1
) (
    input  logic [W-1:0] w_in,
    input  logic         en,
    input  stage_ctl_t   ctl,
    output logic [W-1:0] w_out
);

    logic [DIST-1:0] lo_in;
    logic [DIST-1:0] hi_in;
    logic [W-1:0]    moved_l;
    logic [W-1:0]    moved_r;

    always_comb begin
        // Bits that enter at the bottom during a left move.
        lo_in = (ctl.kind == FILL_WRAP) ? w_in[W-1:W-DIST] : '0;
        // Bits that enter at the top during a right move.
        hi_in = (ctl.kind == FILL_WRAP) ? w_in[DIST-1:0] : {DIST{ctl.fill_bit}};

        moved_l = {w_in[W-1-DIST:0], lo_in};
        moved_r = {hi_in, w_in[W-1:DIST]};

        if (!en)
            w_out = w_in;
        else if (ctl.go_left)
            w_out = moved_l;
        else
            w_out = moved_r;
    end

endmodule

// File: rtl/bsh_top.sv
module bsh_top
    import bsh_pkg::*;
#(
    parameter  int unsigned W  = DW_DEFAULT,
    localparam int unsigned AW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] amt,
    input  logic          dir_left,
    input  logic          fill_sign,
    input  logic          wrap_en,
    output logic [W-1:0]  dout
);

    stage_ctl_t   ctl;
    logic [W-1:0] lvl [AW+1];

    bsh_ctl #(.W(W)) u_ctl (
        .msb       (din[W-1]),
        .dir_left  (dir_left),
        .fill_sign (fill_sign),
        .wrap_en   (wrap_en),
        .ctl       (ctl)
    );

    assign lvl[AW] = din;

    // Largest distance first: lvl[k+1] feeds the stage for 2^k.
    for (genvar k = AW - 1; k >= 0; k--) begin : g_stage
        bsh_stage #(
            .W    (W),
            .DIST (stage_dist(k))
        ) u_stage (
            .w_in  (lvl[k+1]),
            .en    (amt[k]),
            .ctl   (ctl),
            .w_out (lvl[k])
        );
    end

    assign dout = lvl[0];

endmodule

// File: rtl/bsh_checker.sv
module bsh_checker #(
    parameter int unsigned W  = 16,
    parameter int unsigned AW = 4
) (
    input logic [W-1:0]  din,
    input logic [AW-1:0] amt,
    input logic          dir_left,
    input logic          fill_sign,
    input logic          wrap_en,
    input logic [W-1:0]  dout
);

    logic [W-1:0] lo_mask;
    logic [W-1:0] hi_mask;

    always_comb begin
        lo_mask = ~({W{1'b1}} << amt);
        hi_mask = ~({W{1'b1}} >> amt);

        if (amt == '0) begin
            p_zero_amount_identity_r1: assert (dout == din)
                else $error("R1 zero amount changed the word");
        end
        if (dir_left && !wrap_en) begin
            p_left_low_zero_r2: assert ((dout & lo_mask) == '0)
                else $error("R2 left shift left nonzero low bits");
        end
        if (!dir_left && !wrap_en && !fill_sign) begin
            p_right_high_zero_r3: assert ((dout & hi_mask) == '0)
                else $error("R3 logical right shift left nonzero high bits");
        end
        if (!dir_left && !wrap_en && fill_sign) begin
            p_sign_kept_r4: assert (dout[W-1] == din[W-1])
                else $error("R4 arithmetic right shift lost the sign");
            p_sign_fill_r4: assert ((dout & hi_mask) == (din[W-1] ? hi_mask : '0))
                else $error("R4 vacated bits differ from the sign");
        end
        if (wrap_en) begin
            p_rotate_keeps_ones_r5: assert ($countones(dout) == $countones(din))
                else $error("R5/R6 rotation changed the number of ones");
        end
    end

endmodule

bind bsh_top bsh_checker #(.W(W), .AW(AW)) u_bsh_chk (
    .din       (din),
    .amt       (amt),
    .dir_left  (dir_left),
    .fill_sign (fill_sign),
    .wrap_en   (wrap_en),
    .dout      (dout)
);

// File: tb/bsh_top_test.sv
module bsh_top_test;

    localparam int unsigned W        = 16;
    localparam int unsigned AW       = 4;
    localparam time         CLK_HALF = 5ns;
    localparam int          WATCHDOG = 150000;

    typedef struct {
        logic [W-1:0] exp;
        string        tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W-1:0]  din = '0;
    logic [AW-1:0] amt = '0;
    logic          dir_left = 1'b0;
    logic          fill_sign = 1'b0;
    logic          wrap_en = 1'b0;
    logic [W-1:0]  dout;

    item_t sb_q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;

    always #CLK_HALF clk = ~clk;

    bsh_top #(.W(W)) uut (
        .din       (din),
        .amt       (amt),
        .dir_left  (dir_left),
        .fill_sign (fill_sign),
        .wrap_en   (wrap_en),
        .dout      (dout)
    );

    // Behavioural model, written per output bit.
    function automatic logic [W-1:0] model(input logic [W-1:0] d, input int k,
                                           input logic left, input logic sgn, input logic rot);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            int src;
            src = left ? i - k : i + k;
            if (rot)
                r[i] = d[(src + W) % W];
            else if (src < 0)
                r[i] = 1'b0;
            else if (src >= W)
                r[i] = (sgn && !left) ? d[W-1] : 1'b0;
            else
                r[i] = d[src];
        end
        return r;
    endfunction

    // Driver: apply inputs between edges and queue the expected result.
    task automatic drive(input logic [W-1:0] d, input int k, input logic left,
                         input logic sgn, input logic rot, input logic [W-1:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        din       = d;
        amt       = AW'(k);
        dir_left  = left;
        fill_sign = sgn;
        wrap_en   = rot;
        it.exp    = exp;
        it.tag    = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compare on the following rising edge.
    always @(posedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_checks++;
            if (dout !== it.exp) begin
                n_fail++;
                $display("FAIL %s: din=%h amt=%0d left=%0b sign=%0b wrap=%0b got %h expected %h",
                         it.tag, din, amt, dir_left, fill_sign, wrap_en, dout, it.exp);
            end
        end
    end

    function automatic string tag_of(input int k, input logic left, input logic sgn, input logic rot);
        if (k == 0)            return "R1";
        if (k == W - 1 && left && !rot) return "R8";
        if (rot && left)       return "R6";
        if (rot)               return "R5";
        if (left)              return "R2";
        if (sgn)               return "R4";
        return "R3";
    endfunction

    initial begin
        logic [W-1:0] pats [10];
        logic [W-1:0] lfsr;
        pats[0] = 16'h8000; pats[1] = 16'h0001; pats[2] = 16'hA5C3;
        pats[3] = 16'h7FFF; pats[4] = 16'hFFFF; pats[5] = 16'h0000;
        pats[6] = 16'h1234; pats[7] = 16'hC001;
        lfsr = 16'hACE1;
        for (int p = 8; p < 10; p++) begin
            for (int s = 0; s < 7; s++)
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            pats[p] = lfsr;
        end

        // Reset state: all-zero inputs must give an all-zero word (R1).
        drive('0, 0, 1'b0, 1'b0, 1'b0, '0, "R1 reset");
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // Fixed corner values from the requirements.
        drive(16'h0001, 1,  1'b0, 1'b0, 1'b1, 16'h8000, "R5 wrap example");
        drive(16'h8000, 1,  1'b1, 1'b0, 1'b1, 16'h0001, "R6 wrap example");
        drive(16'h8000, 15, 1'b0, 1'b1, 1'b0, 16'hFFFF, "R4 full sign fill");
        drive(16'h0001, 15, 1'b1, 1'b0, 1'b0, 16'h8000, "R8 max left");
        drive(16'hFFFF, 15, 1'b0, 1'b0, 1'b0, 16'h0001, "R3 max logical right");

        // Full sweep: every amount, direction and fill mode.
        for (int p = 0; p < 10; p++)
            for (int k = 0; k < W; k++)
                for (int m = 0; m < 8; m++) begin
                    logic l, sg, ro;
                    l  = m[0]; sg = m[1]; ro = m[2];
                    drive(pats[p], k, l, sg, ro, model(pats[p], k, l, sg, ro), tag_of(k, l, sg, ro));
                end

        // R7: the fill bit is irrelevant for left moves and rotations.
        for (int p = 0; p < 10; p++)
            for (int k = 1; k < W; k++)
                for (int m = 0; m < 3; m++) begin
                    logic l, ro;
                    l  = (m != 1);
                    ro = (m != 0);
                    drive(pats[p], k, l, 1'b1, ro, model(pats[p], k, l, 1'b0, ro), "R7");
                end

        while (sb_q.size() > 0) @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule